// File: doc/BRIEF.md
# Byte Sum of Absolute Differences

This unit compares two 32-bit words lane by lane. Each word is treated as four unsigned bytes. For each byte position the unit forms the magnitude of the difference between the two bytes. It then adds the four magnitudes into one unsigned scalar. An optional 32-bit accumulator term can be added to that scalar. This lets a block-matching search keep a running cost across several word pairs: the caller feeds the previous total back in as the accumulator.

A request is one cycle with `in_valid` high. The operands, the accumulator word and the accumulate-enable bit are sampled on that edge. The registered result appears together with `out_valid` one cycle later. Requests may arrive on every cycle with no gaps.

Top module: `byte_sad_unit`

## Requirements
- R1: Lane k of an operand (k = 0..3) is bits [8k+7:8k] and is read as an unsigned value from 0 to 255. A difference in one lane affects the result only by that lane's own magnitude.
- R2: With accumulation off, the result is the sum over the four lanes of |a_k - b_k|. This sum is never above 1020 and is zero-extended to 32 bits.
- R3: With accumulation on, the result is the accumulator word plus the lane sum, taken modulo 2^32. A carry out of bit 31 is dropped and no flag is raised.
- R4: When `acc_en` is 0, the value on `acc_in` has no effect on the result.
- R5: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. `out_sum` carries the result of that request in the same cycle.
- R6: While reset is asserted, and after it is released until the first request, `out_valid` is 0 and `out_sum` is 0.
- R7: After a cycle with `in_valid` low, `out_sum` keeps its previous value.
- R8: Equal operands give a lane sum of zero, so the result is 0 without accumulation and equals `acc_in` with accumulation.
- R9: Lanes (1,2,3,4) against (4,3,2,1) give 8. With accumulation and `acc_in` = 10 they give 18.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe; inputs are sampled when high |
| acc_en | input | 1 | 1 adds `acc_in` to the lane sum |
| op_a | input | 32 | First operand, four unsigned byte lanes |
| op_b | input | 32 | Second operand, four unsigned byte lanes |
| acc_in | input | 32 | Accumulator term |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_sum | output | 32 | Registered result |

## Verification
The bench targets lanes where b exceeds a. A design that kept the raw 8-bit difference would return 252 where 4 is expected. It checks the all-ones against all-zeros case, where a sum only 8 bits wide would wrap 1020 down to 252. An accumulator near 2^32 checks that the carry is dropped cleanly. A nonzero `acc_in` with accumulation off would expose a design that adds it anyway. Single-lane stimuli catch swapped lane slices. Idle gaps and back-to-back streams catch results that arrive a cycle late or drift while the unit is idle.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = 4;
  localparam int unsigned ACC_W  = 32;

  // how a lane forms its magnitude
  typedef enum logic [0:0] {
    ABS_DUAL_SUB = 1'b0,  // both differences, pick by compare
    ABS_NEGATE   = 1'b1   // one wide difference, negate on borrow
  } abs_style_e;

  // largest lane sum for a given lane width and lane count
  function automatic int unsigned max_lane_sum(int unsigned w, int unsigned n);
    return n * ((1 << w) - 1);
  endfunction
endpackage

// File: rtl/sad_lane.sv
module sad_lane
  import sad_pkg::*;
#(
  parameter int unsigned W     = LANE_W,
  parameter abs_style_e  STYLE = ABS_NEGATE
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] mag
);
  generate
    if (STYLE == ABS_DUAL_SUB) begin : g_dual
      logic [W-1:0] x_minus_y;
      logic [W-1:0] y_minus_x;
      logic         x_ge_y;
      always_comb begin
        x_minus_y = x - y;
        y_minus_x = y - x;
        x_ge_y    = (x >= y);
        mag       = x_ge_y ? x_minus_y : y_minus_x;
      end
    end else begin : g_neg
      logic [W:0]   wide;
      logic         borrow;
      always_comb begin
        wide   = {1'b0, x} - {1'b0, y};
        borrow = wide[W];
        mag    = borrow ? W'(~wide[W-1:0] + 1'b1) : wide[W-1:0];
      end
    end
  endgenerate

  // equal bytes must cancel
  always_comb begin
    if (x == y) begin
      AST_LANE_ZERO: assert (mag == '0); // R8
    end
  end
endmodule

// File: rtl/sad_reduce.sv
module sad_reduce
  import sad_pkg::*;
#(
  parameter int unsigned W = LANE_W,
  parameter int unsigned N = LANES
) (
  input  logic [N-1:0][W-1:0]        leaf,
  output logic [W+$clog2(N)-1:0]     total
);
  localparam int unsigned SUM_W = W + $clog2(N);
  localparam int unsigned NODES = 2 * N;

  // heap-ordered tree: leaves at N..2N-1, root at 1
  logic [SUM_W-1:0] node [1:NODES-1];

  generate
    for (genvar i = 0; i < N; i++) begin : g_leaf
      assign node[N+i] = SUM_W'(leaf[i]);
    end
    for (genvar k = 1; k < N; k++) begin : g_add
      assign node[k] = node[2*k] + node[2*k+1];
    end
  endgenerate

  assign total = node[1];

  always_comb begin
    AST_ROOT_RANGE: assert (32'(total) <= max_lane_sum(W, N)); // R2
  end
endmodule

// File: rtl/byte_sad_unit.sv
module byte_sad_unit
  import sad_pkg::*;
#(
  parameter int unsigned LW    = LANE_W,
  parameter int unsigned NL    = LANES,
  parameter int unsigned AW    = ACC_W,
  parameter abs_style_e  STYLE = ABS_NEGATE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              acc_en,
  input  logic [NL*LW-1:0]  op_a,
  input  logic [NL*LW-1:0]  op_b,
  input  logic [AW-1:0]     acc_in,
  output logic              out_valid,
  output logic [AW-1:0]     out_sum
);
  localparam int unsigned SUM_W   = LW + $clog2(NL);
  localparam int unsigned MAX_RAW = max_lane_sum(LW, NL);

  logic [NL-1:0][LW-1:0] lane_mag;
  logic [SUM_W-1:0]      raw_sum;
  logic [AW-1:0]         raw_ext;
  logic [AW-1:0]         next_sum;

  generate
    for (genvar i = 0; i < NL; i++) begin : g_lane
      sad_lane #(.W(LW), .STYLE(STYLE)) u_lane (
        .x   (op_a[i*LW +: LW]),
        .y   (op_b[i*LW +: LW]),
        .mag (lane_mag[i])
      );
    end
  endgenerate

  sad_reduce #(.W(LW), .N(NL)) u_tree (
    .leaf  (lane_mag),
    .total (raw_sum)
  );

  always_comb begin
    raw_ext  = AW'(raw_sum);
    next_sum = acc_en ? (acc_in + raw_ext) : raw_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_sum <= next_sum;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R5
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_sum)); // R7
  AST_PLAIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !acc_en) |=> (out_sum <= AW'(MAX_RAW))); // R2
endmodule

// File: tb/byte_sad_unit_tb_top.sv
module byte_sad_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        acc_en;
  logic [31:0] op_a;
  logic [31:0] op_b;
  logic [31:0] acc_in;
  logic        out_valid;
  logic [31:0] out_sum;

  int unsigned checks = 0;
  int unsigned errors = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic [31:0] last_sum = 32'd0;
  logic        iv_q = 1'b0;
  logic        done = 1'b0;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #10 clk = ~clk; // 50 MHz

  byte_sad_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_en(acc_en),
    .op_a(op_a), .op_b(op_b), .acc_in(acc_in),
    .out_valid(out_valid), .out_sum(out_sum)
  );

  // independent reference: per-lane signed-int distance
  function automatic logic [31:0] ref_sad(logic [31:0] a, logic [31:0] b,
                                          logic [31:0] c, logic en);
    int s = 0;
    for (int k = 0; k < 4; k++) begin
      int ak = int'(a[8*k +: 8]);
      int bk = int'(b[8*k +: 8]);
      s += (ak > bk) ? (ak - bk) : (bk - ak);
    end
    return en ? (c + 32'(s)) : 32'(s);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%08h) expected %0d (0x%08h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic send(logic [31:0] a, logic [31:0] b, logic [31:0] c, logic en, string tag);
    @(negedge clk);
    op_a = a; op_b = b; acc_in = c; acc_en = en; in_valid = 1'b1;
    exp_q.push_back(ref_sad(a, b, c, en));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_a = lfsr; op_b = ~lfsr; acc_in = lfsr ^ 32'h5A5A_5A5A; acc_en = lfsr[3];
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    end
  endtask

  always @(posedge clk) iv_q <= rst_n ? in_valid : 1'b0;

  // monitor: latency and scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R5 out_valid timing", {31'd0, out_valid}, {31'd0, iv_q});
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check("R5 unexpected result", out_sum, 32'hxxxx_xxxx);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, out_sum, e);
          last_sum = e;
        end
      end else begin
        check("R7 idle hold", out_sum, last_sum);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; acc_en = 1'b0;
    op_a = '0; op_b = '0; acc_in = '0;
    repeat (3) @(negedge clk);
    check("R6 reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R6 reset out_sum", out_sum, 32'd0);
    rst_n = 1'b1;
    idle(3);
    check("R6 after reset out_sum", out_sum, 32'd0);

    send(32'h0403_0201, 32'h0102_0304, 32'd0,  1'b0, "R9 example plain");
    send(32'h0403_0201, 32'h0102_0304, 32'd10, 1'b1, "R9 example accumulated");
    idle(2);
    send(32'hFFFF_FFFF, 32'h0000_0000, 32'd0, 1'b0, "R2 maximum 1020");
    send(32'h0000_0000, 32'hFFFF_FFFF, 32'd0, 1'b0, "R2 maximum b over a");
    send(32'h0102_0304, 32'h0506_0708, 32'd0, 1'b0, "R2 b exceeds a in every lane");
    send(32'h0000_0000, 32'h0000_0010, 32'd0, 1'b0, "R1 lane 0 only");
    send(32'h0000_0000, 32'h0000_2000, 32'd0, 1'b0, "R1 lane 1 only");
    send(32'h0030_0000, 32'h0000_0000, 32'd0, 1'b0, "R1 lane 2 only");
    send(32'h8000_0000, 32'h0000_0000, 32'd0, 1'b0, "R1 lane 3 only");
    send(32'hFFFF_FFFF, 32'h0403_0201, 32'hFFFF_FFFF, 1'b1, "R3 wrap near 2^32");
    send(32'h0403_0201, 32'h0102_0304, 32'hFFFF_FFF8, 1'b1, "R3 wrap to zero");
    send(32'h0403_0201, 32'h0102_0304, 32'h1234_5678, 1'b0, "R4 acc_in ignored");
    send(32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, "R4 acc_in all ones ignored");
    send(32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'd0, 1'b0, "R8 equal operands");
    send(32'h1357_9BDF, 32'h1357_9BDF, 32'hCAFE_0001, 1'b1, "R8 equal operands accumulated");
    idle(4);
    for (int i = 0; i < 40; i++) begin
      logic [31:0] a, b;
      a = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      b = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      send(a, b, a ^ b, b[0], "R2 R3 back-to-back stream");
      if (i % 7 == 6) idle(1 + (i % 3));
    end
    idle(3);
    check("R5 queue drained", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule